// File: doc/BRIEF.md
# Bit-Address Zone Access Permission Logic

This block sits beside a bit-serial protected memory. For the bit address currently selected, it decides which of four operations may go ahead: read the bit, erase it (force it to 1), write it (force it to 0), or compare it against a presented code bit. The answer depends on three things. The first is where the address falls in the fixed partition map: manufacturer area, issuer area, master code and its retry counter, protected code area, four application zones with their code, key and counter fields, test area, fuse cells, and unmapped gaps. The second is the security level. The third is the set of sticky validation flags that are held outside the block.

The security level comes from an external personalization pin and the stored state of the internal fuse. Each application zone carries two enable bits in the first two bits of its data area. The block takes each of them from the memory data bit when the surrounding sequencer signals that the bit at the current address is valid. The four permission outputs are combinational in the address, the level, the flags and the stored enable bits. This lets the serial engine gate an access in the same cycle it selects the address.

Top module: `zone_access_guard`

## Requirements
- R1: Level 1 applies only while fusePin=1 and fuseIntact=1. Any other combination gives level 2. Example: at address 20 with masterOk=1, write is granted at level 1 and refused at level 2.
- R2: Addresses 0–15 grant read only, at both levels and with any flags.
- R3: Addresses 16040–16055 grant read, erase and write, and never compare.
- R4: Addresses 16288–16303 are always readable and never erasable. They are writable only while masterOk=1.
- R5: Addresses 16056–16287 and 16304–16383 grant nothing.
- R6: When loadEn=1 at the first data bit of a zone (216, 9816, 11904 or 13992), memBit becomes that zone's write-enable. At the second data bit (start+1), memBit becomes its read-enable. The new value takes effect from the next cycle, and the load cycle itself uses the old value. Reset clears every enable.
- R7: At level 1 with masterOk=1, every address from 16 to 16055 grants read, erase and write, with no compare.
- R8: At level 1 with masterOk=0, the following rules apply:
  - Issuer area (16–79) and zone fields are handled as follows: the issuer area is read-only, zone code and key fields grant nothing, and zone data is readable exactly when its read-enable is 1.
  - Master code (80–95) grants compare only.
- R9: At level 2:
  - The issuer area is read-only.
  - The master code field is never readable. It grants compare while masterOk=0, and erase and write once masterOk=1.
- R10: At level 2, zone data grants the following:
  - read = readEnable OR (masterOk AND zoneOk).
  - write = masterOk AND zoneOk AND writeEnable.
  - erase = masterOk AND zoneOk AND zoneKeyOk.
  - compare is never granted.
- R11: At level 2, zone code fields and zone erase-key fields grant as follows:
  - Zone code fields grant compare when masterOk=1 and zoneOk=0, and erase and write when both are 1.
  - Erase-key fields grant compare when masterOk and zoneOk are 1 and zoneKeyOk=0, and erase and write when all three are 1.
- R12: Counter and protected fields are always readable and grant as follows:
  - Master counter (96–103): write always; erase with masterOk.
  - Protected area (104–167): erase and write with masterOk.
  - Zone-1 access counter (184–191) at level 2: write with masterOk; erase with masterOk AND zoneOk.
  - Erase counters (8 bits before each data area) at level 2: write with masterOk AND zoneOk; erase additionally needs zoneKeyOk.
  - At level 1, every counter and the protected area grant erase and write with masterOk.
- R13: Whenever compare is granted, read, erase and write are all refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears zone enables |
| bitAddr | input | 14 | Current bit address |
| fusePin | input | 1 | Personalization pin, 1 requests level 1 |
| fuseIntact | input | 1 | Internal fuse state, 1 = not blown |
| masterOk | input | 1 | Sticky master-code valid flag |
| zoneOk | input | 4 | Sticky per-zone access-code valid flags |
| zoneKeyOk | input | 4 | Sticky per-zone erase-key valid flags |
| loadEn | input | 1 | memBit holds the bit at bitAddr this cycle |
| memBit | input | 1 | Memory data bit at bitAddr |
| allowRead | output | 1 | Read permitted |
| allowErase | output | 1 | Erase (write 1) permitted |
| allowWrite | output | 1 | Write (write 0) permitted |
| allowCompare | output | 1 | Compare permitted |

## Verification
A zone enable can be loaded in the same cycle that the permission for that very address is being asked. This happens when loadEn is raised at a zone's second data bit while the outputs are sampled. The bench does this directly and also lets random stimulus land loads on zone start bits. It then judges that the load cycle still shows the previous enable and that the following cycle shows the new one. Every step is compared against a reference computed from the requirements and from a bench-side copy of the loaded enables.

// File: rtl/zone_access_pkg.sv
package zone_access_pkg;
  localparam int ADDR_W    = 14;
  localparam int NUM_ZONES = 4;
  localparam int ZONE_W    = $clog2(NUM_ZONES);

  localparam int unsigned ISS_LO   = 16;
  localparam int unsigned MCODE_LO = 80;
  localparam int unsigned MCNT_LO  = 96;
  localparam int unsigned CPZ_LO   = 104;
  localparam int unsigned ZONES_LO = 168;
  localparam int unsigned TEST_LO  = 16040;
  localparam int unsigned TEST_HI  = 16055;
  localparam int unsigned FUSE_LO  = 16288;
  localparam int unsigned FUSE_HI  = 16303;

  // offsets of zone fields measured back from the zone data start
  localparam int unsigned CNT_BACK   = 8;
  localparam int unsigned KEY_BACK   = 24;
  localparam int unsigned ACNT_BACK  = 32;
  localparam int unsigned CODE_BACK0 = 48;
  localparam int unsigned CODE_BACKN = 40;

  typedef enum logic [3:0] {
    F_NONE, F_FAB, F_ISS, F_MCODE, F_MCNT, F_CPZ, F_ZCODE,
    F_ZCNT, F_EKEY, F_ECNT, F_ZDATA, F_TEST, F_FUSE
  } fieldE;

  typedef struct packed {
    logic rd;
    logic er;
    logic wr;
    logic cmp;
  } permS;

  typedef struct packed {
    logic              capWr;
    logic              capRd;
    logic              bitVal;
    logic [ZONE_W-1:0] zone;
  } capS;

  function automatic int unsigned dataLo(input int z);
    case (z)
      0:       return 216;
      1:       return 9816;
      2:       return 11904;
      default: return 13992;
    endcase
  endfunction

  function automatic int unsigned dataHi(input int z);
    if (z < NUM_ZONES - 1) return dataLo(z + 1) - CODE_BACKN - 1;
    return TEST_LO - 1;
  endfunction
endpackage

// File: rtl/zone_addr_path.sv
module zone_addr_path
  import zone_access_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bitAddr,
  input  logic                 fusePin,
  input  logic                 fuseIntact,
  input  capS                  cap,
  output fieldE                field,
  output logic [ZONE_W-1:0]    zone,
  output logic                 atFirst,
  output logic                 atSecond,
  output logic                 lvl1,
  output logic [NUM_ZONES-1:0] rdEnQ,
  output logic [NUM_ZONES-1:0] wrEnQ
);
  int unsigned a;

  assign lvl1 = fusePin & fuseIntact;

  always_comb begin
    a        = 32'(bitAddr);
    field    = F_NONE;
    zone     = '0;
    atFirst  = 1'b0;
    atSecond = 1'b0;
    if (a < ISS_LO)                       field = F_FAB;
    else if (a < MCODE_LO)                field = F_ISS;
    else if (a < MCNT_LO)                 field = F_MCODE;
    else if (a < CPZ_LO)                  field = F_MCNT;
    else if (a < ZONES_LO)                field = F_CPZ;
    else if (a >= TEST_LO && a <= TEST_HI) field = F_TEST;
    else if (a >= FUSE_LO && a <= FUSE_HI) field = F_FUSE;
    else begin
      for (int z = 0; z < NUM_ZONES; z++) begin
        if (a >= dataLo(z) && a <= dataHi(z)) begin
          field    = F_ZDATA;
          zone     = ZONE_W'(z);
          atFirst  = (a == dataLo(z));
          atSecond = (a == dataLo(z) + 1);
        end else if (a >= dataLo(z) - CNT_BACK && a < dataLo(z)) begin
          field = F_ECNT;
          zone  = ZONE_W'(z);
        end else if (a >= dataLo(z) - KEY_BACK && a < dataLo(z) - CNT_BACK) begin
          field = F_EKEY;
          zone  = ZONE_W'(z);
        end else if (z == 0 && a >= dataLo(z) - ACNT_BACK && a < dataLo(z) - KEY_BACK) begin
          field = F_ZCNT;
          zone  = ZONE_W'(z);
        end else if (a >= dataLo(z) - ((z == 0) ? CODE_BACK0 : CODE_BACKN) &&
                     a < dataLo(z) - ((z == 0) ? ACNT_BACK : KEY_BACK)) begin
          field = F_ZCODE;
          zone  = ZONE_W'(z);
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_ZONES; g++) begin : gEnable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdEnQ[g] <= 1'b0;
        wrEnQ[g] <= 1'b0;
      end else if (cap.zone == ZONE_W'(g)) begin
        if (cap.capRd) rdEnQ[g] <= cap.bitVal;
        if (cap.capWr) wrEnQ[g] <= cap.bitVal;
      end
    end
  end
endmodule

// File: rtl/zone_perm_ctrl.sv
module zone_perm_ctrl
  import zone_access_pkg::*;
(
  input  fieldE                field,
  input  logic [ZONE_W-1:0]    zone,
  input  logic                 atFirst,
  input  logic                 atSecond,
  input  logic                 lvl1,
  input  logic                 masterOk,
  input  logic [NUM_ZONES-1:0] zoneOk,
  input  logic [NUM_ZONES-1:0] zoneKeyOk,
  input  logic [NUM_ZONES-1:0] rdEnQ,
  input  logic [NUM_ZONES-1:0] wrEnQ,
  input  logic                 loadEn,
  input  logic                 memBit,
  output permS                 perm,
  output capS                  cap
);
  logic sv, sn, en, rn, pn, snv;

  assign sv  = masterOk;
  assign sn  = zoneOk[zone];
  assign en  = zoneKeyOk[zone];
  assign rn  = rdEnQ[zone];
  assign pn  = wrEnQ[zone];
  assign snv = sv & sn;

  always_comb begin
    cap.zone   = zone;
    cap.bitVal = memBit;
    cap.capWr  = loadEn & (field == F_ZDATA) & atFirst;
    cap.capRd  = loadEn & (field == F_ZDATA) & atSecond;
  end

  always_comb begin
    perm = '0;
    unique case (field)
      F_FAB:  perm.rd = 1'b1;
      F_ISS: begin
        perm.rd = 1'b1;
        perm.er = lvl1 & sv;
        perm.wr = lvl1 & sv;
      end
      F_MCODE: begin
        perm.rd  = lvl1 & sv;
        perm.er  = sv;
        perm.wr  = sv;
        perm.cmp = ~sv;
      end
      F_MCNT: begin
        perm.rd = 1'b1;
        perm.er = sv;
        perm.wr = 1'b1;
      end
      F_CPZ: begin
        perm.rd = 1'b1;
        perm.er = sv;
        perm.wr = sv;
      end
      F_ZCODE: begin
        if (lvl1) begin
          perm.rd = sv;
          perm.er = sv;
          perm.wr = sv;
        end else begin
          perm.er  = snv;
          perm.wr  = snv;
          perm.cmp = sv & ~sn;
        end
      end
      F_ZCNT: begin
        perm.rd = 1'b1;
        perm.er = lvl1 ? sv : snv;
        perm.wr = sv;
      end
      F_EKEY: begin
        if (lvl1) begin
          perm.rd = sv;
          perm.er = sv;
          perm.wr = sv;
        end else begin
          perm.er  = snv & en;
          perm.wr  = snv & en;
          perm.cmp = snv & ~en;
        end
      end
      F_ECNT: begin
        perm.rd = 1'b1;
        perm.er = lvl1 ? sv : (snv & en);
        perm.wr = lvl1 ? sv : snv;
      end
      F_ZDATA: begin
        if (lvl1) begin
          perm.rd = sv | rn;
          perm.er = sv;
          perm.wr = sv;
        end else begin
          perm.rd = rn | snv;
          perm.er = snv & en;
          perm.wr = snv & pn;
        end
      end
      F_TEST: begin
        perm.rd = 1'b1;
        perm.er = 1'b1;
        perm.wr = 1'b1;
      end
      F_FUSE: begin
        perm.rd = 1'b1;
        perm.wr = sv;
      end
      default: perm = '0;
    endcase
  end
endmodule

// File: rtl/zone_access_guard.sv
module zone_access_guard
  import zone_access_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bitAddr,
  input  logic                 fusePin,
  input  logic                 fuseIntact,
  input  logic                 masterOk,
  input  logic [NUM_ZONES-1:0] zoneOk,
  input  logic [NUM_ZONES-1:0] zoneKeyOk,
  input  logic                 loadEn,
  input  logic                 memBit,
  output logic                 allowRead,
  output logic                 allowErase,
  output logic                 allowWrite,
  output logic                 allowCompare
);
  fieldE                field;
  logic [ZONE_W-1:0]    zone;
  logic                 atFirst, atSecond, lvl1;
  logic [NUM_ZONES-1:0] rdEnQ, wrEnQ;
  permS                 perm;
  capS                  cap;

  zone_addr_path uPath (
    .clk(clk), .rst_n(rst_n), .bitAddr(bitAddr), .fusePin(fusePin),
    .fuseIntact(fuseIntact), .cap(cap), .field(field), .zone(zone),
    .atFirst(atFirst), .atSecond(atSecond), .lvl1(lvl1),
    .rdEnQ(rdEnQ), .wrEnQ(wrEnQ)
  );

  zone_perm_ctrl uCtrl (
    .field(field), .zone(zone), .atFirst(atFirst), .atSecond(atSecond),
    .lvl1(lvl1), .masterOk(masterOk), .zoneOk(zoneOk), .zoneKeyOk(zoneKeyOk),
    .rdEnQ(rdEnQ), .wrEnQ(wrEnQ), .loadEn(loadEn), .memBit(memBit),
    .perm(perm), .cap(cap)
  );

  assign allowRead    = perm.rd;
  assign allowErase   = perm.er;
  assign allowWrite   = perm.wr;
  assign allowCompare = perm.cmp;
endmodule

// File: rtl/zone_access_guard_chk.sv
module zone_access_guard_chk
  import zone_access_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bitAddr,
  input logic              fusePin,
  input logic              fuseIntact,
  input logic              masterOk,
  input logic              loadEn,
  input logic              memBit,
  input logic              allowRead,
  input logic              allowErase,
  input logic              allowWrite,
  input logic              allowCompare
);
  // R2
  fab_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitAddr < ADDR_W'(ISS_LO)) |-> (allowRead && !allowErase && !allowWrite && !allowCompare));

  // R3
  test_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitAddr >= ADDR_W'(TEST_LO) && bitAddr <= ADDR_W'(TEST_HI))
      |-> (allowRead && allowErase && allowWrite && !allowCompare));

  // R4
  fuse_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitAddr >= ADDR_W'(FUSE_LO) && bitAddr <= ADDR_W'(FUSE_HI))
      |-> (allowRead && !allowErase && (!allowWrite || masterOk)));

  // R5
  gap_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bitAddr > ADDR_W'(TEST_HI) && bitAddr < ADDR_W'(FUSE_LO)) || bitAddr > ADDR_W'(FUSE_HI))
      |-> !(allowRead || allowErase || allowWrite || allowCompare));

  // R9
  mcode_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fusePin && fuseIntact) && bitAddr >= ADDR_W'(MCODE_LO) && bitAddr < ADDR_W'(MCNT_LO))
      |-> !allowRead);

  // R6
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEn && memBit && bitAddr == ADDR_W'(dataLo(0) + 1))
      |=> (bitAddr != ADDR_W'(dataLo(0) + 1) || allowRead));

  // R13
  cmp_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    allowCompare |-> !(allowRead || allowErase || allowWrite));
endmodule

bind zone_access_guard zone_access_guard_chk u_chk (.*);

// File: tb/sim_zone_access_guard.sv
module sim_zone_access_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bitAddr = '0;
  logic        fusePin = 1'b0, fuseIntact = 1'b1, masterOk = 1'b0;
  logic [3:0]  zoneOk = '0, zoneKeyOk = '0;
  logic        loadEn = 1'b0, memBit = 1'b0;
  logic        allowRead, allowErase, allowWrite, allowCompare;

  int   nRun = 0, nFail = 0;
  bit   done = 0;
  logic [3:0] mRd = '0, mWr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zone_access_guard u0 (.*);

  function automatic int unsigned zLo(input int z);
    int unsigned t[4] = '{216, 9816, 11904, 13992};
    return t[z];
  endfunction

  function automatic int unsigned zHi(input int z);
    return (z < 3) ? zLo(z + 1) - 41 : 16039;
  endfunction

  // expected {read, erase, write, compare}
  function automatic logic [3:0] refPerm(input int unsigned a, input bit l1, input bit sv,
      input logic [3:0] zf, input logic [3:0] ek, input logic [3:0] rn, input logic [3:0] pn,
      output string tag);
    tag = "R5";
    if (a < 16) begin tag = "R2"; return 4'b1000; end
    if (a < 80) begin tag = l1 ? (sv ? "R7" : "R8") : "R9";
      return (l1 && sv) ? 4'b1110 : 4'b1000; end
    if (a < 96) begin
      tag = l1 ? (sv ? "R7" : "R8") : "R9";
      if (l1) return sv ? 4'b1110 : 4'b0001;
      return sv ? 4'b0110 : 4'b0001;
    end
    if (a < 104) begin tag = "R12"; return {1'b1, sv, 1'b1, 1'b0}; end
    if (a < 168) begin tag = "R12"; return {1'b1, sv, sv, 1'b0}; end
    if (a >= 16040 && a <= 16055) begin tag = "R3"; return 4'b1110; end
    if (a >= 16288 && a <= 16303) begin tag = "R4"; return {1'b1, 1'b0, sv, 1'b0}; end
    if (a > 16039) return 4'b0000;
    for (int z = 0; z < 4; z++) begin
      int d;
      bit s, e;
      if (a < zLo(z) - ((z == 0) ? 48 : 40) || a > zHi(z)) continue;
      d = int'(a) - int'(zLo(z));
      s = zf[z]; e = ek[z];
      if (d >= 0) begin
        tag = l1 ? (sv ? "R7" : "R8") : "R10";
        if (l1) return sv ? 4'b1110 : {rn[z], 3'b000};
        return {rn[z] | (sv & s), sv & s & e, sv & s & pn[z], 1'b0};
      end
      if (d >= -8) begin tag = "R12";
        return l1 ? {1'b1, sv, sv, 1'b0} : {1'b1, sv & s & e, sv & s, 1'b0}; end
      if (d >= -24) begin tag = l1 ? (sv ? "R7" : "R8") : "R11";
        if (l1) return sv ? 4'b1110 : 4'b0000;
        return {1'b0, sv & s & e, sv & s & e, sv & s & ~e}; end
      if (z == 0 && d >= -32) begin tag = "R12";
        return l1 ? {1'b1, sv, sv, 1'b0} : {1'b1, sv & s, sv, 1'b0}; end
      tag = l1 ? (sv ? "R7" : "R8") : "R11";
      if (l1) return sv ? 4'b1110 : 4'b0000;
      return {1'b0, sv & s, sv & s, sv & ~s};
    end
    return 4'b0000;
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s addr=%0d got=%b expected=%b", tag, bitAddr, got, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {allowRead, allowErase, allowWrite, allowCompare};
  endfunction

  task automatic checkRef();
    string tag;
    logic [3:0] e;
    e = refPerm(32'(bitAddr), fusePin & fuseIntact, masterOk, zoneOk, zoneKeyOk, mRd, mWr, tag);
    check(tag, outs(), e);
    if (allowCompare) check("R13", {allowRead, allowErase, allowWrite}, 3'b000);
  endtask

  task automatic modelLoad();
    for (int z = 0; z < 4; z++) begin
      if (loadEn && 32'(bitAddr) == zLo(z))     mWr[z] = memBit;
      if (loadEn && 32'(bitAddr) == zLo(z) + 1) mRd[z] = memBit;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R6: reset leaves zone 2 read-enable clear at level 2
    @(negedge clk) bitAddr = 14'd9900; #1;
    check("R6", outs(), 4'b0000);

    // R6: load zone 2 read-enable; load cycle keeps old value, next cycle new
    @(negedge clk) bitAddr = 14'd9817; loadEn = 1'b1; memBit = 1'b1; #1;
    check("R6", outs(), 4'b0000);
    @(posedge clk); #1 modelLoad();
    @(negedge clk) loadEn = 1'b0; #1;
    check("R6", outs(), 4'b1000);

    // R1: level selection at the issuer area with master flag set
    masterOk = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) bitAddr = 14'd20; fusePin = k[0]; fuseIntact = k[1]; #1;
      check("R1", {allowWrite}, {k == 3});
    end

    // R4: fuse write needs master flag
    @(negedge clk) bitAddr = 14'd16290; masterOk = 1'b0; #1;
    check("R4", outs(), 4'b1000);

    // random sweep
    for (int i = 0; i < 4000; i++) begin
      int r, z;
      @(negedge clk);
      r = $urandom_range(0, 5);
      z = $urandom_range(0, 3);
      case (r)
        0: bitAddr = 14'($urandom_range(0, 16383));
        1: bitAddr = 14'(zLo(z) + $urandom_range(0, 50) - 48);
        2: bitAddr = 14'($urandom_range(0, 215));
        3: bitAddr = 14'($urandom_range(16030, 16383));
        4: bitAddr = 14'(zHi(z) + $urandom_range(0, 1));
        default: bitAddr = 14'(zLo(z) + $urandom_range(0, 1));
      endcase
      fusePin    = 1'($urandom_range(0, 1));
      fuseIntact = 1'($urandom_range(0, 1));
      masterOk   = 1'($urandom_range(0, 1));
      zoneOk     = 4'($urandom_range(0, 15));
      zoneKeyOk  = 4'($urandom_range(0, 15));
      loadEn     = 1'($urandom_range(0, 1));
      memBit     = 1'($urandom_range(0, 1));
      #1 checkRef();
      @(posedge clk); #1 modelLoad();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule